// File: doc/BRIEF.md
# EDID Read Pointer Restorer

This block sits between the agent issuing display sideband requests and the request framer that serialises them onto the auxiliary channel. It lets every request pass, but it watches the I2C-over-AUX writes that set the sink's EDID segment pointer (I2C device 0x30) and its EDID read offset (I2C device 0x50). From these writes it keeps a private copy of the current segment and offset.

Some sinks lose their internal read pointer when a sequence of I2C reads keeps the middle-of-transaction flag set. To work around this, the block checks each qualifying read that starts partway into a 128-byte EDID block. Before passing that read on, it sends one-byte writes that restore the sink's segment and offset. Only then does it forward the read, unchanged. After each qualifying read, the tracked offset moves on by one 16-byte chunk. When the offset reaches the end of the first or the second block, the tracked segment is cleared.

Requests cross each port with a valid/ready handshake. The framer reports the end of each injected write on a one-cycle completion pulse. The block accepts no new upstream request until the current one, and any writes injected in front of it, have gone downstream.

Top module: `edid_ptr_shim`

## Requirements
- R1: After reset, `up_ready` is 1, `dn_valid` is 0, and the tracked segment and offset are both 0. As a result, a first qualifying read is forwarded with no injected write.
- R2: An accepted I2C write (`up_i2c`=1, `up_read`=0) to address 0x30 with `up_len` nonzero stores `up_byte0` as the segment.
- R3: An accepted I2C write to address 0x50 with `up_len` nonzero stores `up_byte0`, zero-extended, as the offset.
- R4: Native requests (`up_i2c`=0) and I2C reads never change the segment or the offset, whatever their address.
- R5: A request that does not qualify is forwarded once, with all fields unchanged and `dn_inj`=0. It injects nothing and does not advance the offset. A request qualifies only if it is an I2C read with `up_mot`=1 and `up_len` nonzero.
- R6: A qualifying read whose offset is a multiple of 128 is forwarded without any injected write.
- R7: A qualifying read at an offset that is not a multiple of 128, with a nonzero segment, is preceded by two injected writes. The first goes to 0x30 and carries the segment. The second goes to the read's own address and carries the offset's low 8 bits. Each injected write has `dn_inj`=1, `dn_i2c`=1, `dn_read`=0, `dn_mot`=1 and `dn_len`=1.
- R8: In the same case with a zero segment, only the offset write is injected.
- R9: After each injected write is handed over, `dn_valid` and `up_ready` stay 0 until `dn_done` pulses. The next downstream request appears in the cycle after that pulse.
- R10: Each forwarded qualifying read advances the offset by 16, whether or not any write was injected in front of it.
- R11: When the advanced offset equals 0x80 or 0x100, the segment becomes 0.
- R12: While `dn_valid` is 1 and `dn_ready` is 0, the downstream request holds steady. `up_ready` and `dn_valid` are never 1 in the same cycle.
- R13: The offset is 9 bits wide, so it reaches 0x100 without wrapping to 0. The segment reset at 0x100 therefore takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Upstream request accepted this cycle |
| up_i2c | input | 1 | 1 = I2C-over-AUX, 0 = native |
| up_read | input | 1 | 1 = read, 0 = write |
| up_mot | input | 1 | Middle-of-transaction flag |
| up_addr | input | AW (20) | Request address (I2C device address for I2C) |
| up_len | input | LW (8) | Byte count |
| up_byte0 | input | DW (8) | First payload byte of a write |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Framer takes the request |
| dn_i2c | output | 1 | Downstream I2C flag |
| dn_read | output | 1 | Downstream read flag |
| dn_mot | output | 1 | Downstream middle-of-transaction flag |
| dn_addr | output | AW (20) | Downstream address |
| dn_len | output | LW (8) | Downstream byte count |
| dn_byte0 | output | DW (8) | Downstream first payload byte |
| dn_inj | output | 1 | Injected write: send with no address phase and no stop |
| dn_done | input | 1 | Framer finished the injected write in flight |

## Verification
An accepted request shows up on `dn_valid` one cycle after the edge that accepted it. A `dn_done` pulse releases the next downstream request one cycle later. After the forwarded request is handed over, `up_ready` returns one cycle later. The bench drives and samples on falling edges and checks each of these outputs at exactly those offsets. It holds `dn_ready` low for one extra cycle on every downstream request to check that the request stays steady. It also holds off `dn_done` for two cycles to confirm that nothing is issued during the wait. The tracked segment and offset are not visible at the ports, so the bench reads them back through the payload of the injected writes that follow. It compares them against its own arithmetic model over a sweep of segments and starting offsets.

// File: rtl/edid_shim_pkg.sv
package edid_shim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG_REQ,
        ST_SEG_WAIT,
        ST_OFS_REQ,
        ST_OFS_WAIT,
        ST_FWD
    } seq_state_e;

    localparam int unsigned SEG_DEV_DEF  = 32'h30;
    localparam int unsigned EDID_DEV_DEF = 32'h50;
    localparam int unsigned CHUNK_DEF    = 16;
    localparam int unsigned BLOCK_DEF    = 128;

endpackage

// File: rtl/edid_ptr_track.sv
module edid_ptr_track #(
    parameter int unsigned AW       = 20,
    parameter int unsigned LW       = 8,
    parameter int unsigned DW       = 8,
    parameter int unsigned OW       = 9,
    parameter int unsigned SEG_DEV  = 32'h30,
    parameter int unsigned EDID_DEV = 32'h50,
    parameter int unsigned CHUNK    = 16,
    parameter int unsigned BLOCK    = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          cap_i2c,
    input  logic          cap_read,
    input  logic [AW-1:0] cap_addr,
    input  logic [LW-1:0] cap_len,
    input  logic [DW-1:0] cap_byte,
    input  logic          adv_en,
    output logic [DW-1:0] seg_q,
    output logic [DW-1:0] ofs_byte,
    output logic          ofs_aligned
);
    localparam int unsigned BW = $clog2(BLOCK);

    typedef struct packed {
        logic [DW-1:0] seg;
        logic [OW-1:0] ofs;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [OW-1:0] ofs_nx;

    always_comb begin
        trk_d  = trk_q;
        ofs_nx = trk_q.ofs + OW'(CHUNK);
        if (cap_en && cap_i2c && !cap_read && (cap_len != '0)) begin
            if (cap_addr == AW'(SEG_DEV))
                trk_d.seg = cap_byte;
            else if (cap_addr == AW'(EDID_DEV))
                trk_d.ofs = OW'(cap_byte);
        end
        if (adv_en) begin
            trk_d.ofs = ofs_nx;
            if ((ofs_nx == OW'(BLOCK)) || (ofs_nx == OW'(2 * BLOCK)))
                trk_d.seg = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign seg_q       = trk_q.seg;
    assign ofs_byte    = trk_q.ofs[DW-1:0];
    assign ofs_aligned = (trk_q.ofs[BW-1:0] == '0);

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && (!cap_i2c || cap_read) && !adv_en) |=> ($stable(trk_q.seg) && $stable(trk_q.ofs)));

    // R10
    ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> (trk_q.ofs == $past(trk_q.ofs) + OW'(CHUNK)));

    // R11
    seg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && (trk_q.ofs == OW'(BLOCK - CHUNK))) |=> (trk_q.seg == '0));

    // R13
    seg_reset_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && (trk_q.ofs == OW'(2 * BLOCK - CHUNK))) |=> (trk_q.seg == '0));

endmodule

// File: rtl/edid_inject_seq.sv
module edid_inject_seq
    import edid_shim_pkg::*;
#(
    parameter int unsigned AW      = 20,
    parameter int unsigned LW      = 8,
    parameter int unsigned DW      = 8,
    parameter int unsigned SEG_DEV = 32'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic          up_i2c,
    input  logic          up_read,
    input  logic          up_mot,
    input  logic [AW-1:0] up_addr,
    input  logic [LW-1:0] up_len,
    input  logic [DW-1:0] up_byte0,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          dn_i2c,
    output logic          dn_read,
    output logic          dn_mot,
    output logic [AW-1:0] dn_addr,
    output logic [LW-1:0] dn_len,
    output logic [DW-1:0] dn_byte0,
    output logic          dn_inj,
    input  logic          dn_done,
    input  logic [DW-1:0] seg_q,
    input  logic [DW-1:0] ofs_byte,
    input  logic          ofs_aligned,
    output logic          cap_en,
    output logic          adv_en
);
    typedef struct packed {
        seq_state_e    st;
        logic          qual;
        logic          i2c;
        logic          read;
        logic          mot;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [DW-1:0] byte0;
    } seq_t;

    seq_t s_d, s_q;
    logic qual_up;

    assign qual_up = up_i2c && up_read && up_mot && (up_len != '0);

    always_comb begin
        s_d      = s_q;
        up_ready = 1'b0;
        dn_valid = 1'b0;
        dn_i2c   = s_q.i2c;
        dn_read  = s_q.read;
        dn_mot   = s_q.mot;
        dn_addr  = s_q.addr;
        dn_len   = s_q.len;
        dn_byte0 = s_q.byte0;
        dn_inj   = 1'b0;
        cap_en   = 1'b0;
        adv_en   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                up_ready = 1'b1;
                if (up_valid) begin
                    cap_en     = 1'b1;
                    s_d.qual   = qual_up;
                    s_d.i2c    = up_i2c;
                    s_d.read   = up_read;
                    s_d.mot    = up_mot;
                    s_d.addr   = up_addr;
                    s_d.len    = up_len;
                    s_d.byte0  = up_byte0;
                    if (qual_up && !ofs_aligned)
                        s_d.st = (seg_q != '0) ? ST_SEG_REQ : ST_OFS_REQ;
                    else
                        s_d.st = ST_FWD;
                end
            end
            ST_SEG_REQ, ST_OFS_REQ: begin
                dn_valid = 1'b1;
                dn_inj   = 1'b1;
                dn_i2c   = 1'b1;
                dn_read  = 1'b0;
                dn_mot   = 1'b1;
                dn_len   = LW'(1);
                dn_addr  = (s_q.st == ST_SEG_REQ) ? AW'(SEG_DEV) : s_q.addr;
                dn_byte0 = (s_q.st == ST_SEG_REQ) ? seg_q : ofs_byte;
                if (dn_ready)
                    s_d.st = (s_q.st == ST_SEG_REQ) ? ST_SEG_WAIT : ST_OFS_WAIT;
            end
            ST_SEG_WAIT: if (dn_done) s_d.st = ST_OFS_REQ;
            ST_OFS_WAIT: if (dn_done) s_d.st = ST_FWD;
            ST_FWD: begin
                dn_valid = 1'b1;
                if (dn_ready) begin
                    adv_en = s_q.qual;
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    // R12
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_byte0) && $stable(dn_inj) && $stable(dn_len)));

    // R12
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> !dn_valid);

    // R7
    inj_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_inj) |-> (dn_i2c && !dn_read && dn_mot && (dn_len == LW'(1))));

    // R9
    wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && dn_inj) |=> (!dn_valid && !up_ready));

endmodule

// File: rtl/edid_ptr_shim.sv
module edid_ptr_shim
    import edid_shim_pkg::*;
#(
    parameter int unsigned AW       = 20,
    parameter int unsigned LW       = 8,
    parameter int unsigned DW       = 8,
    parameter int unsigned SEG_DEV  = SEG_DEV_DEF,
    parameter int unsigned EDID_DEV = EDID_DEV_DEF,
    parameter int unsigned CHUNK    = CHUNK_DEF,
    parameter int unsigned BLOCK    = BLOCK_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic          up_i2c,
    input  logic          up_read,
    input  logic          up_mot,
    input  logic [AW-1:0] up_addr,
    input  logic [LW-1:0] up_len,
    input  logic [DW-1:0] up_byte0,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          dn_i2c,
    output logic          dn_read,
    output logic          dn_mot,
    output logic [AW-1:0] dn_addr,
    output logic [LW-1:0] dn_len,
    output logic [DW-1:0] dn_byte0,
    output logic          dn_inj,
    input  logic          dn_done
);
    localparam int unsigned OW = $clog2(2 * BLOCK) + 1;

    logic [DW-1:0] seg_q;
    logic [DW-1:0] ofs_byte;
    logic          ofs_aligned;
    logic          cap_en;
    logic          adv_en;

    edid_ptr_track #(
        .AW(AW), .LW(LW), .DW(DW), .OW(OW),
        .SEG_DEV(SEG_DEV), .EDID_DEV(EDID_DEV),
        .CHUNK(CHUNK), .BLOCK(BLOCK)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_i2c(up_i2c), .cap_read(up_read),
        .cap_addr(up_addr), .cap_len(up_len), .cap_byte(up_byte0),
        .adv_en(adv_en),
        .seg_q(seg_q), .ofs_byte(ofs_byte), .ofs_aligned(ofs_aligned)
    );

    edid_inject_seq #(
        .AW(AW), .LW(LW), .DW(DW), .SEG_DEV(SEG_DEV)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready),
        .up_i2c(up_i2c), .up_read(up_read), .up_mot(up_mot),
        .up_addr(up_addr), .up_len(up_len), .up_byte0(up_byte0),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_i2c(dn_i2c), .dn_read(dn_read), .dn_mot(dn_mot),
        .dn_addr(dn_addr), .dn_len(dn_len), .dn_byte0(dn_byte0),
        .dn_inj(dn_inj), .dn_done(dn_done),
        .seg_q(seg_q), .ofs_byte(ofs_byte), .ofs_aligned(ofs_aligned),
        .cap_en(cap_en), .adv_en(adv_en)
    );

endmodule

// File: tb/sim_edid_ptr_shim.sv
`timescale 1ns/1ps
module sim_edid_ptr_shim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0, up_i2c = 1'b0, up_read = 1'b0, up_mot = 1'b0;
    logic [19:0] up_addr = '0;
    logic [7:0]  up_len = '0, up_byte0 = '0;
    logic        up_ready, dn_valid, dn_i2c, dn_read, dn_mot, dn_inj;
    logic        dn_ready = 1'b0, dn_done = 1'b0;
    logic [19:0] dn_addr;
    logic [7:0]  dn_len, dn_byte0;

    int nchk = 0, nfail = 0, cyc = 0;
    logic [7:0] m_seg = '0;
    logic [8:0] m_ofs = '0;

    always #4 clk = ~clk;

    edid_ptr_shim u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nfail++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // At a falling edge with a request expected on dn_*: check it, stall a cycle, take it.
    task automatic take_dn(input string tag, input logic i2c, input logic rd, input logic mot,
                           input logic [19:0] addr, input logic [7:0] len,
                           input logic [7:0] b0, input logic inj);
        chk({tag, " dn_valid"}, dn_valid, 1);
        chk({tag, " dn_inj"}, dn_inj, inj);
        chk({tag, " dn_i2c"}, dn_i2c, i2c);
        chk({tag, " dn_read"}, dn_read, rd);
        chk({tag, " dn_mot"}, dn_mot, mot);
        chk({tag, " dn_addr"}, dn_addr, addr);
        chk({tag, " dn_len"}, dn_len, len);
        if (!rd) chk({tag, " dn_byte0"}, dn_byte0, b0);
        @(posedge clk); @(negedge clk);
        chk("R12 stall dn_valid", dn_valid, 1);
        chk("R12 stall dn_addr", dn_addr, addr);
        chk("R12 excl up_ready", up_ready, 0);
        dn_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        dn_ready = 1'b0;
        if (inj) begin
            for (int k = 0; k < 2; k++) begin
                chk("R9 wait dn_valid", dn_valid, 0);
                chk("R9 wait up_ready", up_ready, 0);
                @(posedge clk); @(negedge clk);
            end
            dn_done = 1'b1;
            @(posedge clk); @(negedge clk);
            dn_done = 1'b0;
        end else begin
            chk("R12 up_ready back", up_ready, 1);
            chk("R12 dn_valid idle", dn_valid, 0);
        end
    endtask

    task automatic issue(input logic i2c, input logic rd, input logic mot,
                         input logic [19:0] addr, input logic [7:0] len, input logic [7:0] b0);
        logic qual;
        logic [8:0] nx;
        qual = i2c && rd && mot && (len != 0);
        chk("R12 up_ready idle", up_ready, 1);
        up_i2c = i2c; up_read = rd; up_mot = mot; up_addr = addr; up_len = len; up_byte0 = b0;
        up_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        up_valid = 1'b0;
        if (qual && (m_ofs[6:0] != 0)) begin
            if (m_seg != 0)
                take_dn("R7 seg write", 1, 0, 1, 20'h30, 1, m_seg, 1);
            take_dn(m_seg != 0 ? "R7 ofs write" : "R8 ofs write", 1, 0, 1, addr, 1, m_ofs[7:0], 1);
        end
        take_dn(qual ? "R6 R10 fwd read" : "R5 fwd", i2c, rd, mot, addr, len, b0, 0);
        if (i2c && !rd && len != 0) begin
            if (addr == 20'h30) m_seg = b0;
            else if (addr == 20'h50) m_ofs = {1'b0, b0};
        end
        if (qual) begin
            nx = m_ofs + 9'd16;
            m_ofs = nx;
            if (nx == 9'h080 || nx == 9'h100) m_seg = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 up_ready", up_ready, 1);
        chk("R1 dn_valid", dn_valid, 0);
        issue(1, 1, 1, 20'h50, 16, 0);          // R1: offset 0, no injection
        issue(1, 1, 1, 20'h50, 16, 0);          // R8: offset 0x10, segment 0
        // R4: native and read requests to the pointer addresses
        issue(0, 0, 0, 20'h30, 1, 8'h05);
        issue(0, 0, 1, 20'h50, 1, 8'h33);
        issue(1, 1, 0, 20'h30, 1, 0);
        issue(1, 1, 1, 20'h50, 0, 0);           // R5: zero length, no advance
        issue(1, 1, 0, 20'h50, 16, 0);          // R5: no mot
        issue(1, 1, 1, 20'h50, 16, 0);          // R10 state visible in payload
        // R2 R3 R11 R13 sweep
        for (int s = 0; s < 3; s++) begin
            for (int o = 0; o < 256; o += 16) begin
                issue(1, 0, 1, 20'h30, 1, 8'(s));
                issue(1, 0, 0, 20'h50, 1, 8'(o));
                for (int r = 0; r < 3; r++)
                    issue(1, 1, 1, 20'h50, 16, 0);
            end
        end
        // R13: walk across 0x100 and beyond
        issue(1, 0, 1, 20'h30, 1, 8'h02);
        issue(1, 0, 1, 20'h50, 1, 8'hE0);
        for (int r = 0; r < 5; r++) issue(1, 1, 1, 20'h50, 16, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule